// File: doc/BRIEF.md
# Shared-Bus Datapath Register Set

This block is the central bus of a microcoded processor datapath. Four sources (an immediate generator, the ALU result, the register-file read port and the memory read port) can each put a 32-bit word onto one shared bus. Each source has its own drive enable, supplied by the microcode sequencer. Four holding registers capture the bus word at the next clock edge when their own load strobe is high:

- the instruction word register;
- the two ALU operand registers;
- the memory address register.

The bus is modelled as a one-hot OR multiplexer instead of tri-state buffers. A combinational clash flag reports any cycle in which more than one source is enabled. The ALU, register file, memory array and sequencer sit outside the block and attach through its ports. The instruction word is exported so that downstream logic can decode its opcode and register specifier fields.

Top module: `shared_bus_regset`

## Requirements
- R1: When exactly one drive enable is high, `bus_word` equals that source's word in the same cycle, and the words of the other sources have no effect on it.
- R2: `drive_clash` is high in the same cycle whenever two or more of the four drive enables are high, and low otherwise.
- R3: When no drive enable is high, `drive_clash` is low. With the default parameter `IDLE_X = 0`, `bus_word` is all zeros. With `IDLE_X = 1`, it is all X.
- R4: When a load strobe (`ld_ir`, `ld_a`, `ld_b` or `ld_ma`) is high in a cycle, the matching register holds that cycle's `bus_word` after the next rising clock edge.
- R5: A register whose load strobe is low keeps its value across the clock edge, whatever is on the bus.
- R6: When several load strobes are high in the same cycle, every selected register captures the same bus word.
- R7: A synchronous active-high `rst` clears all four registers to zero at the next edge, and it takes priority over any load strobe.
- R8: During a clash, `bus_word` is the bitwise OR of the words of all enabled sources.
- R9: The four registers are visible at all times on `ir_word`, `opnd_a`, `opnd_b` and `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| drv_imm | input | 1 | Drive enable for the immediate source |
| drv_alu | input | 1 | Drive enable for the ALU result |
| drv_rf | input | 1 | Drive enable for the register-file port |
| drv_mem | input | 1 | Drive enable for the memory port |
| imm_word | input | 32 | Immediate source word |
| alu_word | input | 32 | ALU result word |
| rf_word | input | 32 | Register-file read word |
| mem_word | input | 32 | Memory read word |
| ld_ir | input | 1 | Load strobe for the instruction register |
| ld_a | input | 1 | Load strobe for operand register A |
| ld_b | input | 1 | Load strobe for operand register B |
| ld_ma | input | 1 | Load strobe for the memory address register |
| bus_word | output | 32 | Current shared bus word |
| drive_clash | output | 1 | More than one drive enable is high |
| ir_word | output | 32 | Instruction register contents |
| opnd_a | output | 32 | Operand register A contents |
| opnd_b | output | 32 | Operand register B contents |
| mem_addr | output | 32 | Memory address register contents |

## Verification
The assertions check on every cycle that the clash flag tracks the count of drive enables. They also check that a lone enabled source reaches the bus, that the bus is zero with no driver, and that each register either takes the previous cycle's bus word or stays unchanged, according to its strobe.

Only the bench's scenarios can show the following:
- the OR value seen during a clash;
- several registers captured from a single bus word;
- reset winning over asserted loads;
- the real register contents built up over a sequence of microcode steps.

// File: rtl/shared_bus_pkg.sv
package shared_bus_pkg;
    localparam int WORD_W  = 32;
    localparam int NUM_SRC = 4;

    // Bit position of each source in the packed drive-enable vector.
    typedef enum int {
        SRC_IMM = 0,
        SRC_ALU = 1,
        SRC_RF  = 2,
        SRC_MEM = 3
    } bus_src_e;

    typedef struct packed {
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] ma;
    } hold_regs_t;
endpackage

// File: rtl/onehot_bus_mux.sv
module onehot_bus_mux #(
    parameter int  W      = 32,
    parameter int  N      = 4,
    parameter bit  IDLE_X = 1'b0
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);
    logic [W-1:0] or_word;

    always_comb begin
        or_word = '0;
        for (int i = 0; i < N; i++) begin
            or_word = or_word | (src[i] & {W{sel[i]}});
        end
    end

    generate
        if (IDLE_X) begin : g_idle_x
            assign bus = (|sel) ? or_word : {W{1'bx}};
        end else begin : g_idle_zero
            assign bus = or_word;
        end
    endgenerate
endmodule

// File: rtl/drive_clash_detect.sv
module drive_clash_detect #(
    parameter int N = 4
) (
    input  logic [N-1:0] sel,
    output logic         clash
);
    localparam int CNT_W = $clog2(N + 1);

    logic [CNT_W-1:0] active_cnt;

    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < N; i++) begin
            active_cnt = active_cnt + CNT_W'(sel[i]);
        end
    end

    assign clash = (active_cnt > CNT_W'(1));
endmodule

// File: rtl/shared_bus_regset.sv
module shared_bus_regset
    import shared_bus_pkg::*;
#(
    parameter bit IDLE_X = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drv_imm,
    input  logic              drv_alu,
    input  logic              drv_rf,
    input  logic              drv_mem,
    input  logic [WORD_W-1:0] imm_word,
    input  logic [WORD_W-1:0] alu_word,
    input  logic [WORD_W-1:0] rf_word,
    input  logic [WORD_W-1:0] mem_word,
    input  logic              ld_ir,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              ld_ma,
    output logic [WORD_W-1:0] bus_word,
    output logic              drive_clash,
    output logic [WORD_W-1:0] ir_word,
    output logic [WORD_W-1:0] opnd_a,
    output logic [WORD_W-1:0] opnd_b,
    output logic [WORD_W-1:0] mem_addr
);
    logic [NUM_SRC-1:0]             drv_vec;
    logic [NUM_SRC-1:0][WORD_W-1:0] src_vec;
    hold_regs_t                     regs_d, regs_q;

    always_comb begin
        drv_vec          = '0;
        drv_vec[SRC_IMM] = drv_imm;
        drv_vec[SRC_ALU] = drv_alu;
        drv_vec[SRC_RF]  = drv_rf;
        drv_vec[SRC_MEM] = drv_mem;
        src_vec          = '0;
        src_vec[SRC_IMM] = imm_word;
        src_vec[SRC_ALU] = alu_word;
        src_vec[SRC_RF]  = rf_word;
        src_vec[SRC_MEM] = mem_word;
    end

    onehot_bus_mux #(
        .W      (WORD_W),
        .N      (NUM_SRC),
        .IDLE_X (IDLE_X)
    ) u_mux (
        .sel (drv_vec),
        .src (src_vec),
        .bus (bus_word)
    );

    drive_clash_detect #(
        .N (NUM_SRC)
    ) u_clash (
        .sel   (drv_vec),
        .clash (drive_clash)
    );

    always_comb begin
        regs_d = regs_q;
        if (ld_ir) regs_d.ir = bus_word;
        if (ld_a)  regs_d.a  = bus_word;
        if (ld_b)  regs_d.b  = bus_word;
        if (ld_ma) regs_d.ma = bus_word;
        if (rst)   regs_d    = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign ir_word  = regs_q.ir;
    assign opnd_a   = regs_q.a;
    assign opnd_b   = regs_q.b;
    assign mem_addr = regs_q.ma;
endmodule

// File: rtl/shared_bus_regset_chk.sv
module shared_bus_regset_chk
    import shared_bus_pkg::*;
#(
    parameter bit IDLE_X = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              drv_imm,
    input logic              drv_alu,
    input logic              drv_rf,
    input logic              drv_mem,
    input logic [WORD_W-1:0] imm_word,
    input logic [WORD_W-1:0] alu_word,
    input logic [WORD_W-1:0] rf_word,
    input logic [WORD_W-1:0] mem_word,
    input logic              ld_ir,
    input logic              ld_a,
    input logic              ld_b,
    input logic              ld_ma,
    input logic [WORD_W-1:0] bus_word,
    input logic              drive_clash,
    input logic [WORD_W-1:0] ir_word,
    input logic [WORD_W-1:0] opnd_a,
    input logic [WORD_W-1:0] opnd_b,
    input logic [WORD_W-1:0] mem_addr
);
    logic [3:0] en_all;
    assign en_all = {drv_mem, drv_rf, drv_alu, drv_imm};

    p_clash_on_r2: assert property (@(posedge clk) disable iff (rst)
        ($countones(en_all) > 1) |-> drive_clash);

    p_clash_off_r2: assert property (@(posedge clk) disable iff (rst)
        ($countones(en_all) <= 1) |-> !drive_clash);

    p_lone_imm_r1: assert property (@(posedge clk) disable iff (rst)
        (drv_imm && $countones(en_all) == 1) |-> (bus_word == imm_word));

    p_lone_alu_r1: assert property (@(posedge clk) disable iff (rst)
        (drv_alu && $countones(en_all) == 1) |-> (bus_word == alu_word));

    p_lone_rf_r1: assert property (@(posedge clk) disable iff (rst)
        (drv_rf && $countones(en_all) == 1) |-> (bus_word == rf_word));

    p_lone_mem_r1: assert property (@(posedge clk) disable iff (rst)
        (drv_mem && $countones(en_all) == 1) |-> (bus_word == mem_word));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!IDLE_X && en_all == 4'b0000) |-> (bus_word == '0));

    p_load_ir_r4: assert property (@(posedge clk) disable iff (rst)
        ld_ir |=> (ir_word == $past(bus_word)));

    p_load_a_r4: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> (opnd_a == $past(bus_word)));

    p_load_b_r4: assert property (@(posedge clk) disable iff (rst)
        ld_b |=> (opnd_b == $past(bus_word)));

    p_load_ma_r4: assert property (@(posedge clk) disable iff (rst)
        ld_ma |=> (mem_addr == $past(bus_word)));

    p_hold_ir_r5: assert property (@(posedge clk) disable iff (rst)
        !ld_ir |=> $stable(ir_word));

    p_hold_a_r5: assert property (@(posedge clk) disable iff (rst)
        !ld_a |=> $stable(opnd_a));

    p_hold_b_r5: assert property (@(posedge clk) disable iff (rst)
        !ld_b |=> $stable(opnd_b));

    p_hold_ma_r5: assert property (@(posedge clk) disable iff (rst)
        !ld_ma |=> $stable(mem_addr));
endmodule

bind shared_bus_regset shared_bus_regset_chk #(.IDLE_X(IDLE_X)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .drv_imm     (drv_imm),
    .drv_alu     (drv_alu),
    .drv_rf      (drv_rf),
    .drv_mem     (drv_mem),
    .imm_word    (imm_word),
    .alu_word    (alu_word),
    .rf_word     (rf_word),
    .mem_word    (mem_word),
    .ld_ir       (ld_ir),
    .ld_a        (ld_a),
    .ld_b        (ld_b),
    .ld_ma       (ld_ma),
    .bus_word    (bus_word),
    .drive_clash (drive_clash),
    .ir_word     (ir_word),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .mem_addr    (mem_addr)
);

// File: tb/shared_bus_regset_test.sv
module shared_bus_regset_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    // en = {mem, rf, alu, imm}; ld = {ma, b, a, ir}
    typedef struct packed {
        logic [3:0]  en;
        logic [3:0]  ld;
        logic [31:0] imm;
        logic [31:0] alu;
        logic [31:0] rf;
        logic [31:0] mem;
        logic [31:0] exp_bus;
        logic        exp_clash;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'b0001, 4'b0001, 32'h0000_0013, 32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003, 32'h0000_0013, 1'b0},
        '{4'b0010, 4'b0010, 32'hDEAD_0004, 32'h1234_5678, 32'hDEAD_0005, 32'hDEAD_0006, 32'h1234_5678, 1'b0},
        '{4'b0100, 4'b0100, 32'hDEAD_0007, 32'hDEAD_0008, 32'hCAFE_0000, 32'hDEAD_0009, 32'hCAFE_0000, 1'b0},
        '{4'b1000, 4'b1000, 32'hDEAD_000A, 32'hDEAD_000B, 32'hDEAD_000C, 32'h0000_1000, 32'h0000_1000, 1'b0},
        '{4'b0001, 4'b1110, 32'hFFFF_FFF0, 32'hDEAD_000D, 32'hDEAD_000E, 32'hDEAD_000F, 32'hFFFF_FFF0, 1'b0},
        '{4'b0000, 4'b0010, 32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD, 32'h0000_0000, 1'b0},
        '{4'b0011, 4'b0000, 32'h0F0F_0000, 32'h0000_00F0, 32'hDEAD_0010, 32'hDEAD_0011, 32'h0F0F_00F0, 1'b1},
        '{4'b1111, 4'b0001, 32'h0000_0001, 32'h0000_0002, 32'h0000_0004, 32'h0000_0008, 32'h0000_000F, 1'b1},
        '{4'b0100, 4'b0000, 32'hDEAD_0012, 32'hDEAD_0013, 32'h55AA_55AA, 32'hDEAD_0014, 32'h55AA_55AA, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        drv_imm = 1'b0, drv_alu = 1'b0, drv_rf = 1'b0, drv_mem = 1'b0;
    logic [31:0] imm_word = '0, alu_word = '0, rf_word = '0, mem_word = '0;
    logic        ld_ir = 1'b0, ld_a = 1'b0, ld_b = 1'b0, ld_ma = 1'b0;
    logic [31:0] bus_word, ir_word, opnd_a, opnd_b, mem_addr;
    logic        drive_clash;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] m_ir = '0, m_a = '0, m_b = '0, m_ma = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shared_bus_regset uut (
        .clk (clk), .rst (rst),
        .drv_imm (drv_imm), .drv_alu (drv_alu), .drv_rf (drv_rf), .drv_mem (drv_mem),
        .imm_word (imm_word), .alu_word (alu_word), .rf_word (rf_word), .mem_word (mem_word),
        .ld_ir (ld_ir), .ld_a (ld_a), .ld_b (ld_b), .ld_ma (ld_ma),
        .bus_word (bus_word), .drive_clash (drive_clash),
        .ir_word (ir_word), .opnd_a (opnd_a), .opnd_b (opnd_b), .mem_addr (mem_addr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, "ir_word",  ir_word,  m_ir);
        chk(req, "opnd_a",   opnd_a,   m_a);
        chk(req, "opnd_b",   opnd_b,   m_b);
        chk(req, "mem_addr", mem_addr, m_ma);
    endtask

    task automatic apply(input vec_t v);
        {drv_mem, drv_rf, drv_alu, drv_imm} = v.en;
        {ld_ma, ld_b, ld_a, ld_ir}          = v.ld;
        imm_word = v.imm;
        alu_word = v.alu;
        rf_word  = v.rf;
        mem_word = v.mem;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7", "reset ir", ir_word, 32'h0);
        chk("R7", "reset a", opnd_a, 32'h0);
        chk("R7", "reset b", opnd_b, 32'h0);
        chk("R7", "reset ma", mem_addr, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            #1;
            // R1 single source, R3 idle bus, R8 OR on clash
            chk(VECS[i].en == 4'b0000 ? "R3" : (VECS[i].exp_clash ? "R8" : "R1"),
                "bus_word", bus_word, VECS[i].exp_bus);
            chk("R2", "drive_clash", {31'b0, drive_clash}, {31'b0, VECS[i].exp_clash});
            if (VECS[i].ld[0]) m_ir = VECS[i].exp_bus;
            if (VECS[i].ld[1]) m_a  = VECS[i].exp_bus;
            if (VECS[i].ld[2]) m_b  = VECS[i].exp_bus;
            if (VECS[i].ld[3]) m_ma = VECS[i].exp_bus;
            @(posedge clk);
            #1;
            // R4 loads, R5 holds, R6 multi-load, R9 visibility
            chk_regs(VECS[i].ld == 4'b1110 ? "R6" : (VECS[i].ld == 4'b0000 ? "R5" : "R4_R9"));
            @(negedge clk);
        end

        // R7: reset wins over all load strobes
        apply('{4'b0001, 4'b1111, 32'h0000_0077, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0});
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_ir = '0; m_a = '0; m_b = '0; m_ma = '0;
        chk_regs("R7");
        @(negedge clk);
        rst = 1'b0;
        // R6: all four take the same word
        #1;
        chk("R1", "bus imm", bus_word, 32'h0000_0077);
        @(posedge clk);
        #1;
        m_ir = 32'h77; m_a = 32'h77; m_b = 32'h77; m_ma = 32'h77;
        chk_regs("R6");
        @(negedge clk);
        // R5: no loads, bus changes, registers hold
        apply('{4'b1000, 4'b0000, 32'h0, 32'h0, 32'h0, 32'h9999_0000, 32'h0, 1'b0});
        @(posedge clk);
        #1;
        chk_regs("R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule